// File: doc/BRIEF.md
# Tiled 2D Word Address Generator

This block issues the word addresses that a DMA engine needs to move a two-dimensional buffer one tile at a time. A start pulse loads the configuration: the buffer row pitch, the tile size, a start offset in elements, and two traversal loops. Each loop sets which dimension it moves along, the stride in elements between the origins of consecutive tiles, and the number of tiles it visits. Inside each tile the scan moves along dimension 0 first and then along dimension 1. Between tiles, loop 0 is the inner loop and loop 1 is the outer loop. If a stride is shorter than the tile, the tiles overlap and the same words are issued again.

Every address is a 32-bit word address. Elements of 4, 8 or 16 bits are packed into one word, so the block issues one address per word and not one per element. The addresses come out over a valid/ready handshake.

A packet filter can block a transfer. If the filter ID is not all ones and the incoming block ID differs from it, the block issues no addresses and raises a skip pulse. A configuration that cannot be walked raises an error pulse and is refused.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, addr_valid_o, done_o, skip_o and cfg_err_o are all low.
- R2: Element index = d0 + d1 * buf_dim0_i, where d0 is the contiguous dimension. Within a tile, words are issued with d0 rising fastest, then d1.
- R3: elem_bits_i values 32, 16, 8 and 4 pack 1, 2, 4 and 8 elements per word. The word address is element index >> log2(elements per word). tile_dim0_i is counted in elements, and each tile row gives tile_dim0_i / (elements per word) addresses.
- R4: The start offset (off0_i, off1_i), in elements, is added to the origin of every tile.
- R5: Traversal loop k takes its dimension from trav_dim_i[k] (0 = d0, 1 = d1), its stride from trav_stride_i[16k+15:16k] and its wrap count from trav_wrap_i[16k+15:16k]. A tile's origin is the offset plus count_k * stride_k for every loop on that dimension. Loop 0 is the inner loop.
- R6: A stride smaller than the tile size is accepted. The overlapping words are issued again.
- R7: A 1x1 tile of 32-bit elements issues exactly one address per tile.
- R8: While addr_valid_o is high and addr_ready_i is low, addr_valid_o stays high and addr_o holds its value.
- R9: One cycle after the handshake of the last word of the last tile, done_o pulses for one cycle and addr_valid_o is low.
- R10: If pkt_id_i is not all ones and blk_id_i differs from it, a start pulse produces a one-cycle skip_o pulse and no addresses. If pkt_id_i is all ones, or the two IDs match, the transfer runs.
- R11: A start pulse raises cfg_err_o for one cycle and produces no addresses when any of these holds:
  - the element width is not 4, 8, 16 or 32;
  - a wrap count is zero;
  - a tile dimension is zero;
  - tile_dim0_i, off0_i, buf_dim0_i or the stride of any loop on dimension 0 is not a multiple of the elements per word.
- R12: A start pulse that arrives while addresses are still being issued is ignored, and that includes the cycle of the final handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the configuration and begin a transfer |
| elem_bits_i | input | 6 | Element width in bits |
| buf_dim0_i | input | 16 | Buffer row pitch in elements |
| tile_dim0_i | input | 16 | Tile width in elements |
| tile_dim1_i | input | 16 | Tile height in rows |
| off0_i | input | 16 | Start offset along dimension 0 |
| off1_i | input | 16 | Start offset along dimension 1 |
| trav_dim_i | input | 2 | Dimension select for each traversal loop |
| trav_stride_i | input | 32 | Stride for each traversal loop, 16 bits per loop |
| trav_wrap_i | input | 32 | Tile count for each traversal loop, 16 bits per loop |
| pkt_id_i | input | 8 | Packet filter ID; all ones turns the filter off |
| blk_id_i | input | 8 | Incoming block ID |
| addr_o | output | 32 | Word address |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Address accepted |
| done_o | output | 1 | Pulse after the last address |
| skip_o | output | 1 | Pulse when the packet filter blocks a start |
| cfg_err_o | output | 1 | Pulse when a configuration is refused |

## Verification
Two events can land in the same cycle: a new start request and the handshake that retires the final word. The bench raises start_i while that final address is being accepted. It then expects done_o to pulse, addr_valid_o to stay low, and no second stream to begin. The bench also pairs a start request with a stalled handshake in the middle of a transfer. In that case addr_o must keep its value and the address sequence must carry on where it left off, without restarting.

// File: rtl/tile_agen_pkg.sv
package tile_agen_pkg;
  function automatic logic width_legal(input logic [5:0] bits);
    return (bits == 6'd4) || (bits == 6'd8) || (bits == 6'd16) || (bits == 6'd32);
  endfunction

  // log2 of elements per 32-bit word
  function automatic logic [1:0] pack_shift(input logic [5:0] bits);
    case (bits)
      6'd4:    return 2'd3;
      6'd8:    return 2'd2;
      6'd16:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tile_cfg_check.sv
module tile_cfg_check
  import tile_agen_pkg::*;
#(
  parameter int DW = 16,
  parameter int NL = 2
) (
  input  logic [5:0]       elem_bits_i,
  input  logic [DW-1:0]    buf_dim0_i,
  input  logic [DW-1:0]    tile_dim0_i,
  input  logic [DW-1:0]    tile_dim1_i,
  input  logic [DW-1:0]    off0_i,
  input  logic [NL-1:0]    trav_dim_i,
  input  logic [NL*DW-1:0] trav_stride_i,
  input  logic [NL*DW-1:0] trav_wrap_i,
  output logic [1:0]       shift_o,
  output logic             err_o
);
  logic [DW-1:0] mask;
  logic [NL-1:0] loop_bad;

  assign shift_o = pack_shift(elem_bits_i);
  assign mask    = DW'((32'd1 << shift_o) - 32'd1);

  for (genvar k = 0; k < NL; k++) begin : g_loop
    logic [DW-1:0] stride, wrap;
    assign stride      = trav_stride_i[k*DW +: DW];
    assign wrap        = trav_wrap_i[k*DW +: DW];
    assign loop_bad[k] = (wrap == '0) || (!trav_dim_i[k] && ((stride & mask) != '0));
  end

  assign err_o = !width_legal(elem_bits_i) || (tile_dim0_i == '0) || (tile_dim1_i == '0) ||
                 (((tile_dim0_i | off0_i | buf_dim0_i) & mask) != '0) || (|loop_bad);
endmodule

// File: rtl/tile_wrap_ctr.sv
module tile_wrap_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  assign last_o = (cnt_o == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (step_i) cnt_o <= last_o ? '0 : cnt_o + W'(1);
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
  parameter int DW = 16,
  parameter int NL = 2,
  parameter int PW = 8,
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [5:0]       elem_bits_i,
  input  logic [DW-1:0]    buf_dim0_i,
  input  logic [DW-1:0]    tile_dim0_i,
  input  logic [DW-1:0]    tile_dim1_i,
  input  logic [DW-1:0]    off0_i,
  input  logic [DW-1:0]    off1_i,
  input  logic [NL-1:0]    trav_dim_i,
  input  logic [NL*DW-1:0] trav_stride_i,
  input  logic [NL*DW-1:0] trav_wrap_i,
  input  logic [PW-1:0]    pkt_id_i,
  input  logic [PW-1:0]    blk_id_i,
  output logic [AW-1:0]    addr_o,
  output logic             addr_valid_o,
  input  logic             addr_ready_i,
  output logic             done_o,
  output logic             skip_o,
  output logic             cfg_err_o
);
  localparam int NC = NL + 2;  // tile word, tile row, then traversal loops

  logic             running_q, done_q, skip_q, err_q;
  logic [1:0]       shift_chk, shift_q;
  logic             cfg_bad, pkt_block, idle_start, accept, hs, fin;
  logic [DW-1:0]    buf0_q, off0_q, off1_q, tw_q, td1_q;
  logic [NL-1:0]    dim_q;
  logic [NL*DW-1:0] stride_q, wrap_q;
  logic [NC-1:0][DW-1:0] lim, cnt;
  logic [NC-1:0]    last, step;
  logic [AW-1:0]    org0, org1, idx;

  tile_cfg_check #(.DW(DW), .NL(NL)) u_check (
    .elem_bits_i  (elem_bits_i),
    .buf_dim0_i   (buf_dim0_i),
    .tile_dim0_i  (tile_dim0_i),
    .tile_dim1_i  (tile_dim1_i),
    .off0_i       (off0_i),
    .trav_dim_i   (trav_dim_i),
    .trav_stride_i(trav_stride_i),
    .trav_wrap_i  (trav_wrap_i),
    .shift_o      (shift_chk),
    .err_o        (cfg_bad)
  );

  assign pkt_block  = (pkt_id_i != '1) && (blk_id_i != pkt_id_i);
  assign idle_start = start_i && !running_q;
  assign accept     = idle_start && !cfg_bad && !pkt_block;
  assign hs         = running_q && addr_ready_i;
  assign fin        = hs && (&last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      skip_q    <= 1'b0;
      err_q     <= 1'b0;
      shift_q   <= '0;
      buf0_q    <= '0;
      off0_q    <= '0;
      off1_q    <= '0;
      tw_q      <= '0;
      td1_q     <= '0;
      dim_q     <= '0;
      stride_q  <= '0;
      wrap_q    <= '0;
    end else begin
      done_q <= fin;
      skip_q <= idle_start && !cfg_bad && pkt_block;
      err_q  <= idle_start && cfg_bad;
      if (accept) begin
        running_q <= 1'b1;
        shift_q   <= shift_chk;
        buf0_q    <= buf_dim0_i;
        off0_q    <= off0_i;
        off1_q    <= off1_i;
        tw_q      <= tile_dim0_i >> shift_chk;
        td1_q     <= tile_dim1_i;
        dim_q     <= trav_dim_i;
        stride_q  <= trav_stride_i;
        wrap_q    <= trav_wrap_i;
      end else if (fin) begin
        running_q <= 1'b0;
      end
    end
  end

  // Counter chain: each stage advances when all inner stages wrap
  assign lim[0]  = tw_q;
  assign lim[1]  = td1_q;
  assign step[0] = hs;

  for (genvar c = 0; c < NC; c++) begin : g_ctr
    if (c >= 2) begin : g_lim
      assign lim[c] = wrap_q[(c-2)*DW +: DW];
    end
    if (c >= 1) begin : g_step
      assign step[c] = step[c-1] && last[c-1];
    end
    tile_wrap_ctr #(.W(DW)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (accept),
      .step_i (step[c]),
      .limit_i(lim[c]),
      .cnt_o  (cnt[c]),
      .last_o (last[c])
    );
  end

  always_comb begin
    org0 = AW'(off0_q);
    org1 = AW'(off1_q);
    for (int k = 0; k < NL; k++) begin
      if (dim_q[k]) org1 = org1 + AW'(cnt[2+k]) * AW'(stride_q[k*DW +: DW]);
      else          org0 = org0 + AW'(cnt[2+k]) * AW'(stride_q[k*DW +: DW]);
    end
    idx = org0 + (AW'(cnt[0]) << shift_q) + (org1 + AW'(cnt[1])) * AW'(buf0_q);
  end

  assign addr_o       = idx >> shift_q;
  assign addr_valid_o = running_q;
  assign done_o       = done_q;
  assign skip_o       = skip_q;
  assign cfg_err_o    = err_q;
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          addr_ready_i,
  input logic          addr_valid_o,
  input logic [AW-1:0] addr_o,
  input logic          done_o,
  input logic          skip_o,
  input logic          cfg_err_o
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o)); // R8
  AST_DONE_AFTER_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(addr_valid_o && addr_ready_i)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !addr_valid_o); // R9
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, skip_o, cfg_err_o})); // R10
  AST_SKIP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> !addr_valid_o && $past(start_i)); // R10
  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !addr_valid_o && $past(start_i)); // R11
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o && start_i && !addr_ready_i |=> $stable(addr_o)); // R12
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .addr_ready_i(addr_ready_i),
  .addr_valid_o(addr_valid_o),
  .addr_o      (addr_o),
  .done_o      (done_o),
  .skip_o      (skip_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_tile_addr_gen.sv
`timescale 1ns/1ps
module tb_tile_addr_gen;
  typedef struct packed {
    logic [5:0]  bits;
    logic [15:0] buf0, td0, td1, off0, off1;
    logic        d0, d1;
    logic [15:0] s0, s1, w0, w1;
    logic [15:0] n_exp;
    logic [31:0] last_exp;
  } vec_t;

  // bits buf0 td0 td1 off0 off1 d0 d1 s0 s1 w0 w1 n last
  localparam vec_t VECS [5] = '{
    '{6'd32, 16'd8,  16'd2,  16'd2, 16'd0, 16'd0, 1'b0, 1'b1, 16'd2,  16'd2, 16'd2, 16'd2, 16'd16, 32'd27}, // R2
    '{6'd8,  16'd16, 16'd8,  16'd2, 16'd4, 16'd1, 1'b0, 1'b1, 16'd4,  16'd1, 16'd2, 16'd2, 16'd16, 32'd15}, // R4 R6 overlap
    '{6'd16, 16'd4,  16'd2,  16'd1, 16'd0, 16'd0, 1'b1, 1'b0, 16'd1,  16'd2, 16'd3, 16'd2, 16'd6,  32'd5},  // R5 dims swapped
    '{6'd4,  16'd16, 16'd16, 16'd1, 16'd8, 16'd0, 1'b0, 1'b1, 16'd16, 16'd1, 16'd1, 16'd1, 16'd2,  32'd2},  // R3
    '{6'd32, 16'd5,  16'd1,  16'd1, 16'd1, 16'd1, 1'b0, 1'b1, 16'd1,  16'd1, 16'd3, 16'd1, 16'd3,  32'd8}   // R7 1x1
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b1;
  logic [5:0] bits;
  logic [15:0] buf0, td0, td1, off0, off1;
  logic [1:0] tdim;
  logic [31:0] tstride, twrap;
  logic [7:0] pkt_id = 8'hFF, blk_id = 8'h00;
  logic [31:0] addr;
  logic valid, done, skip, err;
  int checks = 0, errors = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  tile_addr_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .elem_bits_i(bits),
    .buf_dim0_i(buf0), .tile_dim0_i(td0), .tile_dim1_i(td1), .off0_i(off0), .off1_i(off1),
    .trav_dim_i(tdim), .trav_stride_i(tstride), .trav_wrap_i(twrap),
    .pkt_id_i(pkt_id), .blk_id_i(blk_id), .addr_o(addr), .addr_valid_o(valid),
    .addr_ready_i(ready), .done_o(done), .skip_o(skip), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic apply(input vec_t v);
    bits = v.bits; buf0 = v.buf0; td0 = v.td0; td1 = v.td1; off0 = v.off0; off1 = v.off1;
    tdim = {v.d1, v.d0}; tstride = {v.s1, v.s0}; twrap = {v.w1, v.w0};
  endtask

  // Independent model of the traversal, built from the requirement formulas
  task automatic build(input vec_t v);
    int p, sh, o0, o1;
    sh = (v.bits == 4) ? 3 : (v.bits == 8) ? 2 : (v.bits == 16) ? 1 : 0;
    p  = 1 << sh;
    exp_q.delete();
    for (int w1 = 0; w1 < int'(v.w1); w1++)
      for (int w0 = 0; w0 < int'(v.w0); w0++)
        for (int t1 = 0; t1 < int'(v.td1); t1++)
          for (int t0 = 0; t0 < int'(v.td0); t0 += p) begin
            o0 = int'(v.off0) + (v.d0 ? 0 : w0 * int'(v.s0)) + (v.d1 ? 0 : w1 * int'(v.s1));
            o1 = int'(v.off1) + (v.d0 ? w0 * int'(v.s0) : 0) + (v.d1 ? w1 * int'(v.s1) : 0);
            exp_q.push_back(((o0 + t0) + (o1 + t1) * int'(v.buf0)) >> sh);
          end
  endtask

  task automatic run_vec(input vec_t v, input string req, input int stall_at, input int start_at);
    logic [31:0] hold;
    build(v);
    chk(exp_q.size() == int'(v.n_exp), {req, " count R5"}, exp_q.size(), v.n_exp);
    chk(exp_q[exp_q.size()-1] == int'(v.last_exp), {req, " last R4"}, exp_q[exp_q.size()-1], v.last_exp);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < exp_q.size(); i++) begin
      chk(valid === 1'b1, {req, " valid R2"}, valid, 1);
      chk(addr === 32'(exp_q[i]), {req, " addr R2"}, addr, exp_q[i]);
      if (i == stall_at) begin
        ready = 1'b0;
        hold = addr;
        repeat (3) begin
          @(negedge clk);
          chk(valid === 1'b1 && addr === hold, "R8 hold", addr, hold);
        end
        ready = 1'b1;
      end
      if (i == start_at) start = 1'b1;  // R12 start while busy
      @(negedge clk);
      start = 1'b0;
    end
    chk(done === 1'b1, "R9 done", done, 1);
    chk(valid === 1'b0, "R9/R12 idle after last", valid, 0);
    @(negedge clk);
    chk(done === 1'b0 && valid === 1'b0, "R9 pulse width", {done, valid}, 0);
  endtask

  task automatic run_bad(input vec_t v, input string req);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err === 1'b1, {req, " cfg_err"}, err, 1);
    chk(valid === 1'b0, {req, " no addr"}, valid, 0);
    @(negedge clk);
    chk(err === 1'b0 && valid === 1'b0, {req, " after"}, {err, valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t b;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    chk({valid, done, skip, err} === 4'b0, "R1 in reset", {valid, done, skip, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({valid, done, skip, err} === 4'b0, "R1 after reset", {valid, done, skip, err}, 0);

    for (int i = 0; i < 5; i++)
      run_vec(VECS[i], (i == 3) ? "R3" : (i == 4) ? "R7" : (i == 1) ? "R6" : (i == 2) ? "R5" : "R2", -1, -1);

    run_vec(VECS[1], "R8", 5, -1);                  // stall mid-stream
    run_vec(VECS[0], "R12 mid", -1, 5);             // start while busy
    run_vec(VECS[4], "R12 last", -1, 2);            // start on final handshake

    b = VECS[0]; b.w1 = 16'd0;  run_bad(b, "R11 wrap0");
    b = VECS[0]; b.bits = 6'd12; run_bad(b, "R11 width");
    b = VECS[1]; b.td0 = 16'd6; run_bad(b, "R11 tile width");
    b = VECS[2]; b.s1 = 16'd3;  run_bad(b, "R11 stride align");
    b = VECS[4]; b.td1 = 16'd0; run_bad(b, "R11 tile zero");

    // R10 packet filter mismatch
    pkt_id = 8'd5; blk_id = 8'd6;
    apply(VECS[4]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(skip === 1'b1, "R10 skip", skip, 1);
    chk(valid === 1'b0, "R10 no addr", valid, 0);
    @(negedge clk);
    chk(skip === 1'b0 && valid === 1'b0, "R10 after skip", {skip, valid}, 0);
    // R10 match proceeds
    blk_id = 8'd5;
    run_vec(VECS[4], "R10 match", -1, -1);
    pkt_id = 8'hFF;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule